// File: doc/BRIEF.md
# Serial In-System Programming Controller

This block is the target side of a four-byte serial programming link for an on-chip program memory of 8 KB by default. A programming host holds the `isp_hold` input high, drives a slow serial clock and data line, and reads a reply line back. The block oversamples the serial clock and data with the fast system clock, assembles command frames, and returns reply bytes. It issues read, write and erase requests on a simple synchronous memory port, and keeps a lock level and a small table of identification bytes.

A session opens with an enable frame, and the block echoes a fixed acknowledge byte during that frame. After that, the host can run single-byte reads and writes, a whole-array erase, 256-byte page streams in either direction, lock-level changes, lock readback and identification reads. Dropping `isp_hold` aborts any frame in progress and closes the session. The lock level and the memory contents are left as they were.

Top module: `isp_serial_ctrl`

## Requirements
- R1: After `isp_hold` rises, serial clock edges are ignored until `sck` has been seen low for SETTLE_CLKS consecutive system clocks; any high sample restarts that count.
- R2: A frame whose first byte is 0xAC and whose second byte is 0x53 opens the session at the end of its fourth byte, and the reply during its fourth byte is 0x69.
- R3: Until the session is open, no memory request and no lock change is made, and every reply byte is 0x00.
- R4: Opcode 0x40 writes byte 4 to the address formed from the low five bits of byte 2 (bits 12..8) and byte 3 (bits 7..0). Opcode 0x20 returns the byte at that address as the fourth reply byte.
- R5: Opcodes 0x50 (write) and 0x30 (read) take the upper address from byte 2, then stream exactly 256 data bytes for offsets 0 to 255 in order. The next byte starts a new instruction.
- R6: A frame of 0xAC followed by a byte whose top three bits are 100 raises `mem_erase` for exactly one clock at the end of the frame, which blanks the whole array (blank reads 0xFF).
- R7: A frame of 0xAC followed by 111000 B2 B1 (B2 in bit 1, B1 in bit 0) requests lock level 1 + {B1,B2}. It takes effect only when that level is exactly one above the current level; otherwise nothing changes. The level never falls while power stays applied.
- R8: Opcode 0x24 returns the lock state in the fourth reply byte, with bit 2 set from level 2, bit 3 set from level 3, bit 4 set at level 4, and all other bits 0.
- R9: Opcode 0x28 returns identification byte 0, 1 or 2, selected by bits 1..0 of byte 3; selector 3 returns 0xFF. At lock level 3 or 4 the reply is 0xFF for every selector.
- R10: Dropping `isp_hold` low aborts the current frame, closes the session and clears the bit and byte position. The lock level and the memory contents are unchanged.
- R11: At most one of `mem_rd`, `mem_wr`, `mem_erase` is high in any clock. Read data is taken from `mem_rdata` on the clock after `mem_rd`.
- R12: `mosi` is sampled on rising `sck`, most significant bit first. `miso` changes only after a falling `sck` edge (or on abort), and it carries the reply byte most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the serial clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| isp_hold | input | 1 | Programming hold; high permits a session |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply to the host |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Read request, data due on the next clock |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_erase | output | 1 | Whole-array erase request |
| mem_rdata | input | 8 | Read data from memory |

## Verification
The bench builds the controller with ADDR_W of 13, two synchronizer stages, a 64-clock settle window and three distinct identification values. That lets the highest page (0x1F) and the top byte 0x1FFF be reached, and the settle guard is exercised by a burst of early edges whose low phases stay shorter than the window. The serial clock runs at exactly one sixteenth of the system clock, which tests the synchronizer latency against the tightest permitted timing. The distinct identification values show that the selector and the masking at lock levels 3 and 4 are working.

// File: rtl/isp_pkg.sv
`timescale 1ns/1ps
package isp_pkg;
   localparam logic [7:0] OP_MULTI    = 8'hAC;
   localparam logic [7:0] ARG_OPEN    = 8'h53;
   localparam logic [7:0] OPEN_ECHO   = 8'h69;
   localparam logic [7:0] OP_RD_BYTE  = 8'h20;
   localparam logic [7:0] OP_WR_BYTE  = 8'h40;
   localparam logic [7:0] OP_RD_LOCK  = 8'h24;
   localparam logic [7:0] OP_RD_IDENT = 8'h28;
   localparam logic [7:0] OP_RD_PAGE  = 8'h30;
   localparam logic [7:0] OP_WR_PAGE  = 8'h50;

   typedef enum logic [3:0] {
      CMD_NONE, CMD_OPEN, CMD_ERASE, CMD_SET_LOCK, CMD_RD_BYTE,
      CMD_WR_BYTE, CMD_RD_LOCK, CMD_RD_IDENT, CMD_RD_PAGE, CMD_WR_PAGE
   } cmd_e;

   function automatic cmd_e classify(input logic [7:0] op, input logic [7:0] arg);
      cmd_e k;
      k = CMD_NONE;
      unique case (op)
         OP_MULTI: begin
            if (arg == ARG_OPEN)              k = CMD_OPEN;
            else if (arg[7:5] == 3'b100)      k = CMD_ERASE;
            else if (arg[7:2] == 6'b111000)   k = CMD_SET_LOCK;
         end
         OP_RD_BYTE:  k = CMD_RD_BYTE;
         OP_WR_BYTE:  k = CMD_WR_BYTE;
         OP_RD_LOCK:  k = CMD_RD_LOCK;
         OP_RD_IDENT: k = CMD_RD_IDENT;
         OP_RD_PAGE:  k = CMD_RD_PAGE;
         OP_WR_PAGE:  k = CMD_WR_PAGE;
         default:     k = CMD_NONE;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/isp_edge_sync.sv
`timescale 1ns/1ps
module isp_edge_sync #(
   parameter int STAGES      = 2,
   parameter int SETTLE_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic sck,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s
);
   logic [STAGES-1:0] sck_pipe, mosi_pipe;
   logic              sck_d;
   logic              armed;
   logic              sck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_pipe  <= '0;
         mosi_pipe <= '0;
         sck_d     <= 1'b0;
      end else begin
         sck_pipe  <= {sck_pipe[STAGES-2:0], sck};
         mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
         sck_d     <= sck_pipe[STAGES-1];
      end
   end

   assign sck_s  = sck_pipe[STAGES-1];
   assign mosi_s = mosi_pipe[STAGES-1];

   generate
      if (SETTLE_CLKS == 0) begin : g_no_guard
         assign armed = hold;
      end else begin : g_guard
         localparam int CNT_W = $clog2(SETTLE_CLKS + 1);
         logic [CNT_W-1:0] low_cnt;
         logic             armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt <= '0;
               armed_q <= 1'b0;
            end else if (!hold) begin
               low_cnt <= '0;
               armed_q <= 1'b0;
            end else if (!armed_q) begin
               if (sck_s)
                  low_cnt <= '0;
               else if (low_cnt == CNT_W'(SETTLE_CLKS - 1))
                  armed_q <= 1'b1;
               else
                  low_cnt <= low_cnt + CNT_W'(1);
            end
         end
         assign armed = armed_q & hold;
      end
   endgenerate

   assign sck_rise = armed &  sck_s & ~sck_d;
   assign sck_fall = armed & ~sck_s &  sck_d;
endmodule

// File: rtl/isp_shifter.sv
`timescale 1ns/1ps
module isp_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] tx_next,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso
);
   localparam int BIT_W = $clog2(BYTE_W);
   logic [BIT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_byte   <= '0;
         tx_q      <= '0;
         byte_done <= 1'b0;
      end else if (!hold) begin
         bit_cnt   <= '0;
         tx_q      <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sck_rise) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + BIT_W'(1);
            if (bit_cnt == BIT_W'(BYTE_W - 1))
               byte_done <= 1'b1;
         end
         if (sck_fall) begin
            if (bit_cnt == '0) tx_q <= tx_next;
            else               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign miso = tx_q[BYTE_W-1];
endmodule

// File: rtl/isp_frame_dec.sv
`timescale 1ns/1ps
module isp_frame_dec import isp_pkg::*; #(
   parameter int         ADDR_W    = 13,
   parameter logic [7:0] IDENT_B0  = 8'hA5,
   parameter logic [7:0] IDENT_B1  = 8'h3C,
   parameter logic [7:0] IDENT_B2  = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        tx_next,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              mem_erase,
   output logic              enabled,
   output logic [2:0]        lock_bits
);
   localparam int UP_W   = ADDR_W - 8;
   localparam int LOCK_N = 3;

   logic [1:0]        idx_q;
   logic [7:0]        op_q, lo_q, page_cnt;
   logic [UP_W-1:0]   up_q;
   logic [1:0]        lkreq_q;
   cmd_e              kind_q, kind_now;
   logic              page_on, rd_pend;
   logic [LOCK_N-1:0] lock_q;
   logic [1:0]        lock_cur;

   assign kind_now  = classify(op_q, rx_byte);
   assign lock_cur  = 2'($countones(lock_q));
   assign lock_bits = lock_q;

   function automatic logic [7:0] ident_pick(input logic [1:0] sel, input logic masked);
      logic [7:0] v;
      case (sel)
         2'd0:    v = IDENT_B0;
         2'd1:    v = IDENT_B1;
         2'd2:    v = IDENT_B2;
         default: v = 8'hFF;
      endcase
      return masked ? 8'hFF : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         op_q      <= '0;
         lo_q      <= '0;
         up_q      <= '0;
         lkreq_q   <= '0;
         kind_q    <= CMD_NONE;
         page_on   <= 1'b0;
         page_cnt  <= '0;
         rd_pend   <= 1'b0;
         tx_next   <= '0;
         mem_addr  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
         mem_erase <= 1'b0;
         enabled   <= 1'b0;
         lock_q    <= '0;
      end else if (!hold) begin
         idx_q     <= '0;
         page_on   <= 1'b0;
         page_cnt  <= '0;
         rd_pend   <= 1'b0;
         tx_next   <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_erase <= 1'b0;
         enabled   <= 1'b0;
      end else begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_erase <= 1'b0;
         rd_pend   <= mem_rd;
         if (rd_pend) tx_next <= mem_rdata;

         if (byte_done) begin
            if (page_on) begin
               if (kind_q == CMD_WR_PAGE) begin
                  mem_wr    <= 1'b1;
                  mem_addr  <= {up_q, page_cnt};
                  mem_wdata <= rx_byte;
               end else if (page_cnt != 8'hFF) begin
                  mem_rd   <= 1'b1;
                  mem_addr <= {up_q, page_cnt + 8'd1};
               end
               page_cnt <= page_cnt + 8'd1;
               if (page_cnt == 8'hFF) begin
                  page_on <= 1'b0;
                  idx_q   <= '0;
                  tx_next <= '0;
               end
            end else begin
               unique case (idx_q)
                  2'd0: begin
                     op_q    <= rx_byte;
                     idx_q   <= 2'd1;
                     tx_next <= '0;
                  end
                  2'd1: begin
                     kind_q   <= kind_now;
                     up_q     <= rx_byte[UP_W-1:0];
                     lkreq_q  <= {rx_byte[0], rx_byte[1]};
                     idx_q    <= 2'd2;
                     page_cnt <= '0;
                     if (enabled && (kind_now == CMD_RD_PAGE || kind_now == CMD_WR_PAGE))
                        page_on <= 1'b1;
                     if (enabled && kind_now == CMD_RD_PAGE) begin
                        mem_rd   <= 1'b1;
                        mem_addr <= {rx_byte[UP_W-1:0], 8'h00};
                     end
                  end
                  2'd2: begin
                     lo_q    <= rx_byte;
                     idx_q   <= 2'd3;
                     tx_next <= '0;
                     if (kind_q == CMD_OPEN)
                        tx_next <= OPEN_ECHO;
                     else if (enabled) begin
                        case (kind_q)
                           CMD_RD_BYTE: begin
                              mem_rd   <= 1'b1;
                              mem_addr <= {up_q, rx_byte};
                           end
                           CMD_RD_LOCK:  tx_next <= {3'b000, lock_q, 2'b00};
                           CMD_RD_IDENT: tx_next <= ident_pick(rx_byte[1:0], lock_q[1]);
                           default:      tx_next <= '0;
                        endcase
                     end
                  end
                  default: begin
                     idx_q   <= '0;
                     tx_next <= '0;
                     if (kind_q == CMD_OPEN)
                        enabled <= 1'b1;
                     else if (enabled) begin
                        case (kind_q)
                           CMD_ERASE: mem_erase <= 1'b1;
                           CMD_WR_BYTE: begin
                              mem_wr    <= 1'b1;
                              mem_addr  <= {up_q, lo_q};
                              mem_wdata <= rx_byte;
                           end
                           CMD_SET_LOCK:
                              if ({1'b0, lkreq_q} == {1'b0, lock_cur} + 3'd1)
                                 lock_q <= {lock_q[LOCK_N-2:0], 1'b1};
                           default: ;
                        endcase
                     end
                  end
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/isp_serial_ctrl.sv
`timescale 1ns/1ps
module isp_serial_ctrl #(
   parameter int         ADDR_W      = 13,
   parameter int         SYNC_STAGES = 2,
   parameter int         SETTLE_CLKS = 64,
   parameter logic [7:0] IDENT_B0    = 8'hA5,
   parameter logic [7:0] IDENT_B1    = 8'h3C,
   parameter logic [7:0] IDENT_B2    = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              isp_hold,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              mem_erase,
   input  logic [7:0]        mem_rdata
);
   localparam int BYTE_W = 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie between 9 and 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CLKS < 0) begin : g_bad_settle
         $error("SETTLE_CLKS must not be negative");
      end
   endgenerate

   logic              sck_rise, sck_fall, mosi_s, byte_done, enabled;
   logic [BYTE_W-1:0] rx_byte, tx_next;
   logic [2:0]        lock_bits;

   isp_edge_sync #(.STAGES(SYNC_STAGES), .SETTLE_CLKS(SETTLE_CLKS)) u_sync (
      .clk(clk), .rst_n(rst_n), .hold(isp_hold), .sck(sck), .mosi(mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
   );

   isp_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .hold(isp_hold), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_next(tx_next),
      .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
   );

   isp_frame_dec #(.ADDR_W(ADDR_W), .IDENT_B0(IDENT_B0), .IDENT_B1(IDENT_B1),
                   .IDENT_B2(IDENT_B2)) u_dec (
      .clk(clk), .rst_n(rst_n), .hold(isp_hold), .byte_done(byte_done),
      .rx_byte(rx_byte), .mem_rdata(mem_rdata), .tx_next(tx_next),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_erase(mem_erase), .enabled(enabled),
      .lock_bits(lock_bits)
   );
endmodule

// File: rtl/isp_ctrl_checker.sv
`timescale 1ns/1ps
module isp_ctrl_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       isp_hold,
   input logic       miso,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       mem_erase,
   input logic       enabled,
   input logic       sck_fall,
   input logic [2:0] lock_bits
);
   assert_one_mem_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, mem_erase}));

   assert_ops_need_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || mem_erase) |-> enabled);

   assert_erase_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_erase |=> !mem_erase);

   assert_lock_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

   assert_lock_thermo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_bits == 3'b000) || (lock_bits == 3'b001) ||
      (lock_bits == 3'b011) || (lock_bits == 3'b111));

   assert_hold_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !isp_hold |=> !enabled);

   assert_miso_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (isp_hold && $past(isp_hold) && !$past(sck_fall)) |-> $stable(miso));
endmodule

bind isp_serial_ctrl isp_ctrl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .isp_hold(isp_hold), .miso(miso),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_erase(mem_erase),
   .enabled(enabled), .sck_fall(sck_fall), .lock_bits(lock_bits)
);

// File: tb/tb_isp_serial_ctrl.sv
`timescale 1ns/1ps
module tb_isp_serial_ctrl;
   localparam int AW = 13;
   localparam logic [7:0] ID0 = 8'hA5, ID1 = 8'h3C, ID2 = 8'h0F;

   logic          clk = 1'b0, rst_n = 1'b0, isp_hold = 1'b0, sck = 1'b0, mosi = 1'b0;
   logic          miso, mem_rd, mem_wr, mem_erase;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, mem_rdata = 8'h00;

   isp_serial_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2), .SETTLE_CLKS(64),
                     .IDENT_B0(ID0), .IDENT_B1(ID1), .IDENT_B2(ID2)) dut (
      .clk(clk), .rst_n(rst_n), .isp_hold(isp_hold), .sck(sck), .mosi(mosi),
      .miso(miso), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_erase(mem_erase), .mem_rdata(mem_rdata)
   );

   always #4 clk = ~clk;

   int checks = 0, errors = 0, wr_pulses = 0, erase_pulses = 0, overlap = 0;

   // memory attached to the port
   logic [7:0] mem_model [int];
   always @(posedge clk) begin
      if (mem_erase) begin mem_model.delete(); erase_pulses++; end
      else if (mem_wr) begin mem_model[int'(mem_addr)] = mem_wdata; wr_pulses++; end
      if (mem_rd)
         mem_rdata <= mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'hFF;
      if (int'(mem_rd) + int'(mem_wr) + int'(mem_erase) > 1) overlap++;
   end

   // behavioural reference state
   logic       ref_en = 1'b0;
   int         ref_lvl = 1;
   logic [7:0] ref_mem [int];

   function automatic logic [7:0] ref_rd(input int a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
   endfunction

   function automatic logic [7:0] lock_byte(input int lvl);
      case (lvl)
         2: return 8'h04;
         3: return 8'h0C;
         4: return 8'h1C;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
      end
   endtask

   task automatic check_int(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] o, output logic [7:0] i);
      for (int b = 7; b >= 0; b--) begin
         mosi = o[b];
         repeat (8) @(negedge clk);
         i[b] = miso;
         sck = 1'b1;
         repeat (8) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic frame(input logic [7:0] a, b, c, d, output logic [7:0] r);
      logic [7:0] t;
      xfer(a, t); xfer(b, t); xfer(c, t); xfer(d, r);
   endtask

   task automatic t_open(input string req);
      logic [7:0] r;
      frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
      check(req, "open echo", r, 8'h69);
      ref_en = 1'b1;
   endtask

   task automatic t_wbyte(input int a, input logic [7:0] d);
      logic [7:0] r;
      frame(8'h40, {3'b000, 5'(a >> 8)}, 8'(a), d, r);
      if (ref_en) ref_mem[a] = d;
   endtask

   task automatic t_rbyte(input string req, input int a);
      logic [7:0] r;
      frame(8'h20, {3'b000, 5'(a >> 8)}, 8'(a), 8'h00, r);
      check(req, $sformatf("byte read %04h", a), r, ref_en ? ref_rd(a) : 8'h00);
   endtask

   task automatic t_lockw(input logic [1:0] code);   // code = {B1,B2}
      logic [7:0] r;
      frame(8'hAC, {6'b111000, code[0], code[1]}, 8'h00, 8'h00, r);
      if (ref_en && int'(code) + 1 == ref_lvl + 1) ref_lvl++;
   endtask

   task automatic t_lockr(input string req);
      logic [7:0] r;
      frame(8'h24, 8'h00, 8'h00, 8'h00, r);
      check(req, $sformatf("lock readback lvl %0d", ref_lvl), r, ref_en ? lock_byte(ref_lvl) : 8'h00);
   endtask

   task automatic t_ident(input string req, input logic [1:0] s);
      logic [7:0] r, e;
      frame(8'h28, 8'h00, {6'b0, s}, 8'h00, r);
      case (s) 2'd0: e = ID0; 2'd1: e = ID1; 2'd2: e = ID2; default: e = 8'hFF; endcase
      if (ref_lvl >= 3) e = 8'hFF;
      if (!ref_en) e = 8'h00;
      check(req, $sformatf("ident %0d lvl %0d", s, ref_lvl), r, e);
   endtask

   initial begin : wdog
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [7:0] r, t;
      int w0, bad;
      repeat (5) @(negedge clk);
      check("reset", "miso", {7'b0, miso}, 8'h00);
      check("reset", "mem req", {5'b0, mem_rd, mem_wr, mem_erase}, 8'h00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      isp_hold = 1'b1;
      repeat (10) @(negedge clk);
      // R1: early edges (low phases of 8 clocks, below the window) must not count
      xfer(8'hAC, t);
      repeat (80) @(negedge clk);
      // R3: closed session ignores writes and replies 0x00
      t_wbyte(5, 8'h12);
      t_rbyte("R3", 5);
      t_open("R1");
      check_int("R3", "writes while closed", wr_pulses, 0);
      t_rbyte("R3", 5);
      frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
      check("R12", "msb-first echo", r, 8'h69);
      check("R2", "echo when already open", r, 8'h69);
      // R4: byte mode
      t_wbyte(16'h0000, 8'h11);
      t_wbyte(16'h1FFF, 8'hEE);
      t_wbyte(16'h0ABC, 8'hC3);
      t_wbyte(16'h1EFF, 8'h33);
      t_rbyte("R4", 16'h0000);
      t_rbyte("R4", 16'h1FFF);
      t_rbyte("R4", 16'h0ABC);
      // R5: page mode on the top page
      w0 = wr_pulses;
      xfer(8'h50, t); xfer(8'h1F, t);
      for (int k = 0; k < 256; k++) begin
         xfer(8'(k) ^ 8'h5A, t);
         ref_mem[16'h1F00 + k] = 8'(k) ^ 8'h5A;
      end
      check_int("R5", "page write count", wr_pulses - w0, 256);
      xfer(8'h30, t); xfer(8'h1F, t);
      bad = 0;
      for (int k = 0; k < 256; k++) begin
         xfer(8'h00, r);
         if (r !== (8'(k) ^ 8'h5A)) begin
            bad++;
            if (bad == 1) check("R5", $sformatf("page byte %0d", k), r, 8'(k) ^ 8'h5A);
         end
      end
      check_int("R5", "page read mismatches", bad, 0);
      t_rbyte("R5", 16'h1EFF);
      t_rbyte("R5", 16'h1F80);
      // R7 R8 R9: lock sequencing and ident masking
      t_lockr("R8");
      t_ident("R9", 2'd0); t_ident("R9", 2'd1); t_ident("R9", 2'd2); t_ident("R9", 2'd3);
      t_lockw(2'b10); t_lockr("R7");
      t_lockw(2'b01); t_lockr("R8");
      t_ident("R9", 2'd1);
      t_lockw(2'b11); t_lockr("R7");
      t_lockw(2'b10); t_lockr("R8");
      t_ident("R9", 2'd0);
      t_lockw(2'b11); t_lockr("R8");
      t_ident("R9", 2'd2);
      t_lockw(2'b01); t_lockr("R7");
      // R6: erase
      frame(8'hAC, 8'h9F, 8'h00, 8'h00, r);
      ref_mem.delete();
      check_int("R6", "erase pulses", erase_pulses, 1);
      t_rbyte("R6", 16'h1FFF);
      t_rbyte("R6", 16'h0ABC);
      t_wbyte(16'h0100, 8'h77);
      // R10: abort mid-frame
      xfer(8'h40, t); xfer(8'h01, t);
      isp_hold = 1'b0;
      ref_en = 1'b0;
      repeat (5) @(negedge clk);
      isp_hold = 1'b1;
      repeat (80) @(negedge clk);
      t_rbyte("R10", 16'h0100);
      t_open("R10");
      t_rbyte("R10", 16'h0100);
      t_lockr("R10");
      check_int("R11", "overlapping requests", overlap, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule